// File: doc/BRIEF.md
# SDRAM Read Burst Output Pipeline

This block is the device-side read data path of a 16-bit synchronous DRAM model. It receives already-decoded commands (no operation, read, write, precharge) with a bank and a column, and puts the addressed words onto the data bus after a programmable column-access latency of 1, 2 or 3 clocks. Each of the two byte lanes has its own output enable and its own mask input. A mask acts on the output enables two clocks after it is sampled, whatever the column-access latency is.

A burst sequencer issues one column per clock. Column addressing is sequential and wraps inside the aligned block of the burst length. A delay line then holds each issued word until its latency has elapsed. A later read cuts a running burst short on any clock, and the new burst follows the old one with no idle cycle. A write cuts it short and empties the delay line. A precharge of the burst's bank, or a precharge of all banks, stops the issue of new words. Words that were already issued still drain from the delay line. The storage array is modelled by a fixed function of bank and column, so every word on the bus can be predicted.

The sequencer has two states. `ST_IDLE` issues nothing. A read moves it to `ST_RUN`, or keeps it in `ST_IDLE` when the burst is one word long. `ST_RUN` issues the next word on each clock. It returns to `ST_IDLE` after the last word, on a write, or on a precharge that hits the burst's bank. A read seen in `ST_RUN` restarts the burst and the sequencer stays in `ST_RUN`.

Top module: `rdp_read_out`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `data_out` is 0 and both output enables are low. A reset during a burst discards every word that is still pending.
- R2: A read sampled in cycle t puts its first word on the bus in cycle t+L. L is the latency selected by `cas_lat`: code 1 gives 1, code 2 gives 2, and codes 3 and 0 both give 3.
- R3: `burst_sel` codes 0, 1, 2 and 3 select burst lengths of 1, 2, 4 and 8. Word k of a burst starting at column c goes to column (c with its low log2(BL) bits cleared) OR ((c+k) mod BL). The words appear on consecutive cycles.
- R4: The word for bank b and column c is 16'h5A00 XOR (b shifted left by 8) XOR c.
- R5: A read in cycle t interrupts a running burst in either bank. The old burst's words continue up to cycle t+L-1, and the new burst starts at cycle t+L with no gap.
- R6: A write (`cmd`=2) in cycle t ends the running burst. From cycle t+1 on, no read word is on the bus.
- R7: A precharge (`cmd`=3) in cycle t ends the running burst when its `bank` equals the burst's bank or when `pre_all` is high. The old words continue up to cycle t+L-1, and no word appears from cycle t+L on.
- R8: A precharge to the other bank with `pre_all` low has no effect on a running burst.
- R9: A high `mask_lo` (`mask_hi`) in cycle t drives `oe_lo` (`oe_hi`) low in cycle t+2, for every latency setting. `data_out` still carries the word.
- R10: In a cycle with no word due, `data_out` is 0 and both output enables are low.
- R11: The burst length is latched with the read. Changing `burst_sel` during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 2 | Decoded command: 0 no-op, 1 read, 2 write, 3 precharge |
| bank | input | 1 | Bank of the command |
| col | input | 8 | Start column of a read |
| pre_all | input | 1 | With a precharge: close both banks |
| burst_sel | input | 2 | Burst length code, sampled with a read |
| cas_lat | input | 2 | Latency code; must stay constant while words are pending |
| mask_lo | input | 1 | Mask for the low byte lane |
| mask_hi | input | 1 | Mask for the high byte lane |
| data_out | output | 16 | Read word driven onto the bus |
| oe_lo | output | 1 | Output enable for bits 7:0 |
| oe_hi | output | 1 | Output enable for bits 15:8 |

## Verification
The reference model gives each cycle after the command its due outputs. A read sampled in cycle t puts its first word in cycle t+L and the following words in the next cycles. A write takes effect in cycle t+1, a precharge in cycle t+L, and a mask in cycle t+2. The bench drives its inputs and samples the outputs on the falling edge. Each sample is compared with the model's entry for that same cycle index, so every register on the path is counted once. The latency code is changed only after all pending words have drained.

// File: rtl/rdp_pkg.sv
package rdp_pkg;

    localparam int COL_W    = 8;
    localparam int BANK_W   = 1;
    localparam int DATA_W   = 16;
    localparam int LANES    = 2;
    localparam int MAX_CL   = 3;
    localparam int MASK_LAT = 2;
    localparam int BLEN_W   = 4;
    localparam int OFFS_W   = BLEN_W - 1;

    localparam logic [DATA_W-1:0] WORD_SEED = 16'h5A00;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_PRE   = 2'd3
    } cmd_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_st_e;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } slot_t;

    // Word stored at a bank/column location (fixed array contents)
    function automatic logic [DATA_W-1:0] word_of(logic [BANK_W-1:0] b,
                                                  logic [COL_W-1:0]  c);
        logic [DATA_W-1:0] bw;
        bw = DATA_W'(b) << COL_W;
        return WORD_SEED ^ bw ^ DATA_W'(c);
    endfunction

    // Burst length from its 2-bit code: 1, 2, 4 or 8
    function automatic logic [BLEN_W-1:0] blen_of(logic [1:0] code);
        return BLEN_W'(1) << code;
    endfunction

    // Latency from its code; code 0 is read as the longest setting
    function automatic logic [1:0] lat_of(logic [1:0] code);
        return (code == 2'd0) ? 2'(MAX_CL) : code;
    endfunction

    // Sequential column inside the aligned block of the burst length
    function automatic logic [COL_W-1:0] wrap_col(logic [COL_W-1:0]  start,
                                                  logic [OFFS_W-1:0] offs,
                                                  logic [BLEN_W-1:0] blen);
        logic [COL_W-1:0] m;
        m = COL_W'(blen - BLEN_W'(1));
        return (start & ~m) | ((start + COL_W'(offs)) & m);
    endfunction

endpackage

// File: rtl/rdp_burst_seq.sv
module rdp_burst_seq
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              pre_all,
    input  logic [1:0]        burst_sel,
    output slot_t             issue,
    output logic              flush
);

    seq_st_e           state, state_n;
    logic [BANK_W-1:0] cur_bank;
    logic [COL_W-1:0]  start_col;
    logic [BLEN_W-1:0] cur_len;
    logic [OFFS_W-1:0] offs;
    logic [BLEN_W-1:0] left;

    cmd_e              c;
    logic              pre_hit;
    logic              load;
    logic              step;
    logic [BLEN_W-1:0] new_len;

    assign c       = cmd_e'(cmd);
    assign new_len = blen_of(burst_sel);
    assign pre_hit = (c == CMD_PRE) && (pre_all || (bank == cur_bank));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Burst bookkeeping: start, length, position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank  <= '0;
            start_col <= '0;
            cur_len   <= BLEN_W'(1);
            offs      <= '0;
            left      <= '0;
        end else if (load) begin
            cur_bank  <= bank;
            start_col <= col;
            cur_len   <= new_len;
            offs      <= OFFS_W'(1);
            left      <= new_len - BLEN_W'(1);
        end else if (step) begin
            offs      <= offs + OFFS_W'(1);
            left      <= left - BLEN_W'(1);
        end
    end

    // Next state and issued slot
    always_comb begin
        state_n = state;
        issue   = '0;
        load    = 1'b0;
        step    = 1'b0;
        flush   = (c == CMD_WRITE);
        unique case (state)
            ST_IDLE: begin
                if (c == CMD_READ) begin
                    load = 1'b1;
                end
            end
            ST_RUN: begin
                if (c == CMD_READ) begin
                    load = 1'b1;
                end else if ((c == CMD_WRITE) || pre_hit) begin
                    state_n = ST_IDLE;
                end else begin
                    step       = 1'b1;
                    issue.vld  = 1'b1;
                    issue.bank = cur_bank;
                    issue.col  = wrap_col(start_col, offs, cur_len);
                    if (left == BLEN_W'(1)) begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (load) begin
            issue.vld  = 1'b1;
            issue.bank = bank;
            issue.col  = col;
            state_n    = (new_len > BLEN_W'(1)) ? ST_RUN : ST_IDLE;
        end
    end

endmodule

// File: rtl/rdp_lat_pipe.sv
module rdp_lat_pipe
    import rdp_pkg::*;
#(
    parameter int DEPTH = MAX_CL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  slot_t      slot_in,
    input  logic       flush,
    input  logic [1:0] lat,
    output slot_t      slot_out
);

    slot_t stg [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    stg[0] <= '0;
                end else begin
                    stg[0] <= slot_in;
                end
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (!rst_n || flush) begin
                    stg[i] <= '0;
                end else begin
                    stg[i] <= stg[i-1];
                end
            end
        end
    end

    // Stage L-1 holds the word issued L cycles after its command
    always_comb begin
        slot_out = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(lat) == k + 1) begin
                slot_out = stg[k];
            end
        end
    end

endmodule

// File: rtl/rdp_mask_delay.sv
module rdp_mask_delay
    import rdp_pkg::*;
#(
    parameter int NLANE = LANES,
    parameter int LAT   = MASK_LAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NLANE-1:0] mask_in,
    output logic [NLANE-1:0] mask_due
);

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [LAT-1:0] sh;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh <= '0;
            end else begin
                sh <= LAT'({sh, mask_in[l]});
            end
        end
        assign mask_due[l] = sh[LAT-1];
    end

endmodule

// File: rtl/rdp_read_out.sv
module rdp_read_out
    import rdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  col,
    input  logic              pre_all,
    input  logic [1:0]        burst_sel,
    input  logic [1:0]        cas_lat,
    input  logic              mask_lo,
    input  logic              mask_hi,
    output logic [DATA_W-1:0] data_out,
    output logic              oe_lo,
    output logic              oe_hi
);

    slot_t            issue;
    slot_t            due_slot;
    logic             flush;
    logic [1:0]       lat;
    logic [LANES-1:0] mask_due;
    logic             word_due;

    assign lat = lat_of(cas_lat);

    rdp_burst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (cmd),
        .bank      (bank),
        .col       (col),
        .pre_all   (pre_all),
        .burst_sel (burst_sel),
        .issue     (issue),
        .flush     (flush)
    );

    rdp_lat_pipe #(.DEPTH(MAX_CL)) u_pipe (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_in  (issue),
        .flush    (flush),
        .lat      (lat),
        .slot_out (due_slot)
    );

    rdp_mask_delay #(.NLANE(LANES), .LAT(MASK_LAT)) u_mask (
        .clk      (clk),
        .rst_n    (rst_n),
        .mask_in  ({mask_hi, mask_lo}),
        .mask_due (mask_due)
    );

    assign word_due = due_slot.vld;
    assign data_out = word_due ? word_of(due_slot.bank, due_slot.col) : '0;
    assign oe_lo    = word_due && !mask_due[0];
    assign oe_hi    = word_due && !mask_due[1];

endmodule

// File: rtl/rdp_read_out_chk.sv
module rdp_read_out_chk
    import rdp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cmd,
    input logic [1:0]        cas_lat,
    input logic              mask_lo,
    input logic              mask_hi,
    input logic              due,
    input logic [DATA_W-1:0] data_out,
    input logic              oe_lo,
    input logic              oe_hi
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R10: nothing due means a quiet, undriven bus
    assert_quiet_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !due |-> (!oe_lo && !oe_hi && data_out == '0));

    // R9: lane masks act two clocks later
    assert_mask_lo_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(mask_lo, 2)) |-> !oe_lo);

    assert_mask_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2 && $past(mask_hi, 2)) |-> !oe_hi);

    // R6: a write leaves nothing due on the next cycle
    assert_write_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(cmd) == CMD_WRITE) |-> !due);

    // R2: with latency 1 the first word follows the read directly
    assert_lat1_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && $past(cmd) == CMD_READ &&
         $past(cas_lat) == 2'd1 && cas_lat == 2'd1) |-> due);

endmodule

bind rdp_read_out rdp_read_out_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .cas_lat  (cas_lat),
    .mask_lo  (mask_lo),
    .mask_hi  (mask_hi),
    .due      (word_due),
    .data_out (data_out),
    .oe_lo    (oe_lo),
    .oe_hi    (oe_hi)
);

// File: tb/rdp_read_out_tb.sv
module rdp_read_out_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cmd;
    logic        bank;
    logic [7:0]  col;
    logic        pre_all;
    logic [1:0]  burst_sel;
    logic [1:0]  cas_lat;
    logic        mask_lo;
    logic        mask_hi;
    logic [15:0] data_out;
    logic        oe_lo;
    logic        oe_hi;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic last_bank = 1'b0;

    localparam int HIST = 2048;
    logic        exp_v  [HIST];
    logic [15:0] exp_d  [HIST];
    logic        hist_lo[HIST];
    logic        hist_hi[HIST];

    always #10 clk = ~clk;

    rdp_read_out u_dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .col(col),
        .pre_all(pre_all), .burst_sel(burst_sel), .cas_lat(cas_lat),
        .mask_lo(mask_lo), .mask_hi(mask_hi),
        .data_out(data_out), .oe_lo(oe_lo), .oe_hi(oe_hi)
    );

    typedef struct packed {
        logic [1:0] cl;
        logic [1:0] cmd;
        logic       bank;
        logic [7:0] col;
        logic       pall;
        logic [1:0] bsel;
        logic       mlo;
        logic       mhi;
        logic [4:0] gap;
        logic [3:0] req;
    } ev_t;

    localparam int NEV = 30;
    localparam ev_t EVTS [NEV] = '{
        '{2'd1, 2'd1, 1'b0, 8'h10, 1'b0, 2'd2, 1'b0, 1'b0, 5'd6,  4'd2 },  // R2 latency 1
        '{2'd2, 2'd1, 1'b1, 8'h21, 1'b0, 2'd2, 1'b0, 1'b0, 5'd7,  4'd3 },  // R3 wrap in 4
        '{2'd3, 2'd1, 1'b0, 8'h35, 1'b0, 2'd3, 1'b0, 1'b0, 5'd12, 4'd3 },  // R3 wrap in 8
        '{2'd3, 2'd1, 1'b0, 8'h02, 1'b0, 2'd0, 1'b0, 1'b0, 5'd5,  4'd3 },  // R3 length 1
        '{2'd2, 2'd1, 1'b0, 8'h40, 1'b0, 2'd1, 1'b0, 1'b0, 5'd4,  4'd4 },  // R4 word values
        '{2'd2, 2'd1, 1'b0, 8'h50, 1'b0, 2'd3, 1'b0, 1'b0, 5'd2,  4'd5 },  // R5 first burst
        '{2'd2, 2'd1, 1'b1, 8'h60, 1'b0, 2'd2, 1'b0, 1'b0, 5'd0,  4'd5 },  // R5 other bank
        '{2'd2, 2'd1, 1'b1, 8'h70, 1'b0, 2'd2, 1'b0, 1'b0, 5'd8,  4'd5 },  // R5 next clock
        '{2'd3, 2'd1, 1'b0, 8'h08, 1'b0, 2'd3, 1'b0, 1'b0, 5'd0,  4'd5 },  // R5
        '{2'd3, 2'd1, 1'b0, 8'h18, 1'b0, 2'd2, 1'b0, 1'b0, 5'd9,  4'd5 },  // R5 same bank
        '{2'd1, 2'd1, 1'b1, 8'h44, 1'b0, 2'd3, 1'b0, 1'b0, 5'd1,  4'd5 },  // R5 latency 1
        '{2'd1, 2'd1, 1'b0, 8'h80, 1'b0, 2'd2, 1'b0, 1'b0, 5'd6,  4'd5 },  // R5
        '{2'd3, 2'd1, 1'b0, 8'h90, 1'b0, 2'd3, 1'b0, 1'b0, 5'd2,  4'd6 },  // R6 burst
        '{2'd3, 2'd2, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 5'd8,  4'd6 },  // R6 write
        '{2'd1, 2'd1, 1'b1, 8'hA0, 1'b0, 2'd3, 1'b0, 1'b0, 5'd1,  4'd6 },  // R6 burst
        '{2'd1, 2'd2, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 5'd5,  4'd6 },  // R6 write
        '{2'd3, 2'd1, 1'b1, 8'hB0, 1'b0, 2'd3, 1'b0, 1'b0, 5'd1,  4'd7 },  // R7 burst
        '{2'd3, 2'd3, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 5'd7,  4'd7 },  // R7 same bank
        '{2'd2, 2'd1, 1'b0, 8'hC0, 1'b0, 2'd3, 1'b0, 1'b0, 5'd2,  4'd7 },  // R7 burst
        '{2'd2, 2'd3, 1'b1, 8'h00, 1'b1, 2'd0, 1'b0, 1'b0, 5'd6,  4'd7 },  // R7 all banks
        '{2'd1, 2'd1, 1'b0, 8'hD0, 1'b0, 2'd3, 1'b0, 1'b0, 5'd1,  4'd7 },  // R7 burst
        '{2'd1, 2'd3, 1'b0, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 5'd5,  4'd7 },  // R7 latency 1
        '{2'd2, 2'd1, 1'b0, 8'hE0, 1'b0, 2'd2, 1'b0, 1'b0, 5'd0,  4'd8 },  // R8 burst
        '{2'd2, 2'd3, 1'b1, 8'h00, 1'b0, 2'd0, 1'b0, 1'b0, 5'd6,  4'd8 },  // R8 other bank
        '{2'd3, 2'd1, 1'b1, 8'h11, 1'b0, 2'd3, 1'b1, 1'b0, 5'd2,  4'd9 },  // R9 low lane
        '{2'd3, 2'd0, 1'b0, 8'h00, 1'b0, 2'd3, 1'b0, 1'b1, 5'd2,  4'd9 },  // R9 high lane
        '{2'd3, 2'd0, 1'b0, 8'h00, 1'b0, 2'd3, 1'b0, 1'b0, 5'd6,  4'd9 },  // R9 release
        '{2'd2, 2'd1, 1'b1, 8'h7C, 1'b0, 2'd2, 1'b0, 1'b0, 5'd8,  4'd11},  // R11 sel changes
        '{2'd1, 2'd0, 1'b0, 8'h00, 1'b0, 2'd1, 1'b0, 1'b0, 5'd4,  4'd10},  // R10 idle
        '{2'd0, 2'd1, 1'b0, 8'h33, 1'b0, 2'd2, 1'b0, 1'b0, 5'd8,  4'd2 }   // R2 code 0
    };

    function automatic logic [15:0] word(logic b, logic [7:0] c);
        return 16'h5A00 ^ {7'd0, b, 8'd0} ^ {8'd0, c};
    endfunction

    function automatic int lat_val(logic [1:0] code);
        return (code == 2'd0) ? 3 : int'(code);
    endfunction

    task automatic clear_from(int first);
        for (int i = first; i < first + 16 && i < HIST; i++) begin
            exp_v[i] = 1'b0;
            exp_d[i] = 16'h0000;
        end
    endtask

    // Reference model: one command in cycle 'cyc'
    task automatic model(logic [1:0] c, logic b, logic [7:0] cl0, logic pa,
                         logic [1:0] bs, logic [1:0] lc);
        int L;
        int bl;
        logic [7:0] m;
        logic [7:0] cc;
        L = lat_val(lc);
        if (c == 2'd1) begin
            clear_from(cyc + L);
            bl = 1 << bs;
            m  = 8'(bl - 1);
            for (int k = 0; k < bl; k++) begin
                cc = (cl0 & ~m) | ((cl0 + 8'(k)) & m);
                exp_v[cyc + L + k] = 1'b1;
                exp_d[cyc + L + k] = word(b, cc);
            end
            last_bank = b;
        end else if (c == 2'd2) begin
            clear_from(cyc + 1);
        end else if (c == 2'd3 && (pa || b == last_bank)) begin
            clear_from(cyc + L);
        end
    endtask

    task automatic check_now(int req);
        logic       ev;
        logic [15:0] ed;
        logic       elo;
        logic       ehi;
        ev  = exp_v[cyc];
        ed  = ev ? exp_d[cyc] : 16'h0000;
        elo = ev && !((cyc >= 2) ? hist_lo[cyc-2] : 1'b0);
        ehi = ev && !((cyc >= 2) ? hist_hi[cyc-2] : 1'b0);
        total++;
        if (data_out !== ed || oe_lo !== elo || oe_hi !== ehi) begin
            bad++;
            $display("FAIL R%0d cycle %0d: actual data=%h hi=%b lo=%b expected data=%h hi=%b lo=%b",
                     req, cyc, data_out, oe_hi, oe_lo, ed, ehi, elo);
        end
    endtask

    task automatic step(logic [1:0] c, logic b, logic [7:0] cl0, logic pa,
                        logic [1:0] bs, logic [1:0] lc, logic ml, logic mh, int req);
        @(negedge clk);
        check_now(req);
        cmd = c; bank = b; col = cl0; pre_all = pa;
        burst_sel = bs; cas_lat = lc; mask_lo = ml; mask_hi = mh;
        hist_lo[cyc] = ml;
        hist_hi[cyc] = mh;
        model(c, b, cl0, pa, bs, lc);
        cyc++;
    endtask

    task automatic check_reset_state(string tag);
        total++;
        if (data_out !== 16'h0000 || oe_lo !== 1'b0 || oe_hi !== 1'b0) begin
            bad++;
            $display("FAIL R1 %s: actual data=%h hi=%b lo=%b expected data=0000 hi=0 lo=0",
                     tag, data_out, oe_hi, oe_lo);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd = 2'd0; mask_lo = 1'b0; mask_hi = 1'b0; pre_all = 1'b0;
        repeat (3) @(negedge clk);
        check_reset_state("held in reset");
        for (int i = 0; i < HIST; i++) begin
            exp_v[i]   = 1'b0;
            exp_d[i]   = 16'h0000;
            hist_lo[i] = 1'b0;
            hist_hi[i] = 1'b0;
        end
        last_bank = 1'b0;
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 190000);
        bad++;
        total++;
        $display("FAIL R1 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cmd = 2'd0; bank = 1'b0; col = 8'h00; pre_all = 1'b0;
        burst_sel = 2'd0; cas_lat = 2'd1; mask_lo = 1'b0; mask_hi = 1'b0;
        apply_reset();
        // R1: first cycle after reset release
        @(negedge clk);
        check_reset_state("after release");
        cyc = 1;

        for (int e = 0; e < NEV; e++) begin
            step(EVTS[e].cmd, EVTS[e].bank, EVTS[e].col, EVTS[e].pall,
                 EVTS[e].bsel, EVTS[e].cl, EVTS[e].mlo, EVTS[e].mhi, int'(EVTS[e].req));
            for (int g = 0; g < int'(EVTS[e].gap); g++) begin
                // R11: burst_sel toggled while the burst runs
                step(2'd0, EVTS[e].bank, EVTS[e].col, 1'b0, ~EVTS[e].bsel,
                     EVTS[e].cl, EVTS[e].mlo, EVTS[e].mhi, int'(EVTS[e].req));
            end
        end

        // R1: reset in the middle of a long burst drops pending words
        step(2'd1, 1'b1, 8'h20, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1);
        for (int g = 0; g < 4; g++) step(2'd0, 1'b0, 8'h00, 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 1);
        apply_reset();
        @(negedge clk);
        check_reset_state("mid-burst reset");
        cyc++;
        for (int g = 0; g < 10; g++) step(2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 10);

        // R2, R5: latency 3 back-to-back reads on every clock
        for (int k = 0; k < 4; k++) step(2'd1, 1'(k), 8'(8'hF0 + k), 1'b0, 2'd3, 2'd3, 1'b0, 1'b0, 5);
        for (int g = 0; g < 12; g++) step(2'd0, 1'b0, 8'h00, 1'b0, 2'd0, 2'd3, 1'b0, 1'b0, 5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule